// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block keeps the two threshold offsets used by a FIFO's flag logic: the almost-empty distance `n` and the almost-full distance `m`. It has no address bus. Each offset is split into a low byte register and a high byte register. The four byte registers are reached one after another by an implicit 2-bit selector. While the load strobe is active, every write-clock edge that also has the write enable active stores the low byte of the data input into the register the selector points at, then moves the selector on. The order is almost-empty low, almost-empty high, almost-full low, almost-full high, and then it wraps back to the start.

The selector keeps its position when a burst ends. A short burst that stops after one or two registers therefore resumes at the next register in the sequence. A second selector runs on the read clock and returns the same registers, in the same order, into a readback register that the FIFO output can present.

Loading and readback are allowed only when the load strobe is held active while reset is asserted. If the strobe is inactive at that time, the pin acts as a second, active-high write enable and the offsets keep their reset value of 7. The block also decodes the plain FIFO write and read strobes from the shared pins. The offsets go to the flag logic at full width.

Top module: `fifo_thresh_loader`

## Requirements
- R1: After reset, both offsets equal 7, the readback register is zero and both selectors point at the almost-empty low register.
- R2: `loadModeOn` is 1 when `ldN` is low during reset and 0 when `ldN` is high during reset. When it is 0, no offset changes and the readback register stays unchanged, whatever the pins do.
- R3: In load mode, a `wrClk` edge with `ldN`=0 and `wrEn1N`=0 stores `dataIn[7:0]` into the selected register. Selector value 0 is almost-empty bits 7:0, 1 is almost-empty bits PTR_W-1:8, 2 is almost-full bits 7:0, and 3 is almost-full bits PTR_W-1:8. High bits beyond PTR_W-1 are dropped.
- R4: The fifth load edge after reset wraps back to the almost-empty low register.
- R5: The write selector keeps its position across gaps, so a new burst continues at the register after the last one written.
- R6: A `wrClk` edge with `ldN`=0 and `wrEn1N`=1 changes no offset and does not move the selector.
- R7: `fifoWrEn` = 1 exactly when `wrEn1N`=0 and `ldN`=1. This holds in both modes, and a FIFO write never changes an offset.
- R8: In load mode, an `rdClk` edge with `ldN`=0, `rdEn1N`=0 and `rdEn2N`=0 loads the selected register, zero-extended, into `cfgRdData` and advances the read selector. The read selector uses the same order and wraps after four registers.
- R9: An `rdClk` edge with `rdEn1N` or `rdEn2N` high, or with `ldN` high, leaves `cfgRdData` and the read selector unchanged.
- R10: `fifoRdEn` = 1 when both read enables are low and either `ldN`=1 or the block is not in load mode.
- R11: When a high register is read back, the bits above PTR_W-9 are zero, even if ones were written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| rstN | input | 1 | Active-low reset; mode is sampled on wrClk while low |
| ldN | input | 1 | Active-low load strobe, or active-high second write enable in two-enable mode |
| wrEn1N | input | 1 | Active-low write enable |
| rdEn1N | input | 1 | Active-low read enable 1 |
| rdEn2N | input | 1 | Active-low read enable 2 |
| dataIn | input | DATA_W | Write data; bits 7:0 feed the offset registers |
| cfgRdData | output | DATA_W | Readback register holding one offset byte |
| almostEmptyOff | output | PTR_W | Full-width almost-empty offset n |
| almostFullOff | output | PTR_W | Full-width almost-full offset m |
| loadModeOn | output | 1 | 1 when load mode was selected at reset |
| fifoWrEn | output | 1 | Decoded FIFO write strobe |
| fifoRdEn | output | 1 | Decoded FIFO read strobe |

## Verification
The bench builds the block with DEPTH=1024 and DATA_W=9. This gives 10-bit offsets, so each high register holds only two live bits. Writing all-ones into a high byte then shows, on the offset outputs, that the extra bits are dropped, and shows in the readback that they return as zeros. The 9-bit data path checks that bit 8 of the write data is ignored and that bit 8 of the readback stays clear.

// File: rtl/thresh_loader_pkg.sv
package thresh_loader_pkg;

  // Selector order: bit 1 picks the offset, bit 0 picks the byte
  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;

  typedef struct packed {
    logic  wrLoad;
    slot_e wrSel;
    logic  rdLoad;
    slot_e rdSel;
  } cfgStrobe_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/thresh_loader_ctrl.sv
module thresh_loader_ctrl
  import thresh_loader_pkg::*;
(
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       ldN,
  input  logic       wrEn1N,
  input  logic       rdEn1N,
  input  logic       rdEn2N,
  output cfgStrobe_t stb,
  output logic       loadModeOn,
  output logic       fifoWrEn,
  output logic       fifoRdEn
);

  logic  loadMode;
  slot_e wrSel;
  slot_e rdSel;
  logic  wrLoad;
  logic  rdLoad;

  // Mode strap sampled on write clock while reset is held
  always_ff @(posedge wrClk) begin
    if (!rstN) loadMode <= ~ldN;
  end

  assign wrLoad = loadMode & ~ldN & ~wrEn1N;
  assign rdLoad = loadMode & ~ldN & ~rdEn1N & ~rdEn2N;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)       wrSel <= SLOT_EMPTY_LO;
    else if (wrLoad) wrSel <= slot_e'(wrSel + 2'd1);
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)       rdSel <= SLOT_EMPTY_LO;
    else if (rdLoad) rdSel <= slot_e'(rdSel + 2'd1);
  end

  always_comb begin
    stb        = '0;
    stb.wrLoad = wrLoad;
    stb.wrSel  = wrSel;
    stb.rdLoad = rdLoad;
    stb.rdSel  = rdSel;
  end

  assign loadModeOn = loadMode;
  // Pin is second active-high enable in either mode, so the decode is shared
  assign fifoWrEn   = ~wrEn1N & ldN;
  assign fifoRdEn   = ~rdEn1N & ~rdEn2N & (ldN | ~loadMode);

  p_wr_step_r5: assert property (@(posedge wrClk) disable iff (!rstN)
    wrLoad |=> (wrSel == slot_e'($past(wrSel) + 2'd1)));

  p_wr_hold_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrLoad |=> $stable(wrSel));

  p_rd_step_r8: assert property (@(posedge rdClk) disable iff (!rstN)
    rdLoad |=> (rdSel == slot_e'($past(rdSel) + 2'd1)));

  p_rd_hold_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdLoad |=> $stable(rdSel));

  p_wr_exclusive_r7: assert property (@(posedge wrClk) disable iff (!rstN)
    fifoWrEn |-> !stb.wrLoad);

endmodule

// File: rtl/thresh_loader_dp.sv
module thresh_loader_dp
  import thresh_loader_pkg::*;
#(
  parameter int PTR_W     = 10,
  parameter int DATA_W    = 9,
  parameter int DEF_EMPTY = 7,
  parameter int DEF_FULL  = 7
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  cfgStrobe_t        stb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] cfgRdData,
  output logic [PTR_W-1:0]  almostEmptyOff,
  output logic [PTR_W-1:0]  almostFullOff
);

  localparam int NUM_OFF = 2;
  localparam int WIDE_W  = PTR_W + BYTE_W;

  logic [PTR_W-1:0] offReg [NUM_OFF];
  logic [BYTE_W-1:0] rdByte;

  function automatic logic [PTR_W-1:0] mergeByte(input logic [PTR_W-1:0] old,
                                                 input logic [BYTE_W-1:0] b,
                                                 input logic hi);
    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] mask;
    wide = '0;
    mask = '0;
    wide[BYTE_W-1:0] = b;
    mask[BYTE_W-1:0] = '1;
    if (hi) begin
      wide = wide << BYTE_W;
      mask = mask << BYTE_W;
    end
    return (old & ~mask[PTR_W-1:0]) | (wide[PTR_W-1:0] & mask[PTR_W-1:0]);
  endfunction

  function automatic logic [BYTE_W-1:0] pickByte(input logic [PTR_W-1:0] val,
                                                 input logic hi);
    logic [WIDE_W-1:0] wide;
    wide = '0;
    wide[PTR_W-1:0] = val;
    if (hi) wide = wide >> BYTE_W;
    return wide[BYTE_W-1:0];
  endfunction

  for (genvar g = 0; g < NUM_OFF; g++) begin : g_off
    localparam logic [PTR_W-1:0] DEF_VAL =
      (g == 0) ? PTR_W'(DEF_EMPTY) : PTR_W'(DEF_FULL);
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN)
        offReg[g] <= DEF_VAL;
      else if (stb.wrLoad && (stb.wrSel[1] == 1'(g)))
        offReg[g] <= mergeByte(offReg[g], dataIn[BYTE_W-1:0], stb.wrSel[0]);
    end
  end

  assign rdByte = pickByte(offReg[stb.rdSel[1]], stb.rdSel[0]);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)           cfgRdData <= '0;
    else if (stb.rdLoad) cfgRdData <= DATA_W'(rdByte);
  end

  assign almostEmptyOff = offReg[0];
  assign almostFullOff  = offReg[1];

  p_off_stable_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    !stb.wrLoad |=> ($stable(almostEmptyOff) && $stable(almostFullOff)));

  p_one_offset_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    (stb.wrLoad && !stb.wrSel[1]) |=> $stable(almostFullOff));

  p_rd_data_hold_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.rdLoad |=> $stable(cfgRdData));

  p_hi_zero_r11: assert property (@(posedge rdClk) disable iff (!rstN)
    (stb.rdLoad && stb.rdSel[0]) |=> ((cfgRdData >> (PTR_W - BYTE_W)) == '0));

endmodule

// File: rtl/fifo_thresh_loader.sv
module fifo_thresh_loader
  import thresh_loader_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int DATA_W    = 9,
  parameter int DEF_EMPTY = 7,
  parameter int DEF_FULL  = 7,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              wrEn1N,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] cfgRdData,
  output logic [PTR_W-1:0]  almostEmptyOff,
  output logic [PTR_W-1:0]  almostFullOff,
  output logic              loadModeOn,
  output logic              fifoWrEn,
  output logic              fifoRdEn
);

  cfgStrobe_t stb;

  thresh_loader_ctrl i_ctrl (
    .wrClk      (wrClk),
    .rdClk      (rdClk),
    .rstN       (rstN),
    .ldN        (ldN),
    .wrEn1N     (wrEn1N),
    .rdEn1N     (rdEn1N),
    .rdEn2N     (rdEn2N),
    .stb        (stb),
    .loadModeOn (loadModeOn),
    .fifoWrEn   (fifoWrEn),
    .fifoRdEn   (fifoRdEn)
  );

  thresh_loader_dp #(
    .PTR_W     (PTR_W),
    .DATA_W    (DATA_W),
    .DEF_EMPTY (DEF_EMPTY),
    .DEF_FULL  (DEF_FULL)
  ) i_dp (
    .wrClk          (wrClk),
    .rdClk          (rdClk),
    .rstN           (rstN),
    .stb            (stb),
    .dataIn         (dataIn),
    .cfgRdData      (cfgRdData),
    .almostEmptyOff (almostEmptyOff),
    .almostFullOff  (almostFullOff)
  );

endmodule

// File: tb/test_fifo_thresh_loader.sv
module test_fifo_thresh_loader;

  localparam int DEPTH  = 1024;
  localparam int DATA_W = 9;
  localparam int PTR_W  = 10;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic rstN = 1'b0;
  logic ldN = 1'b1;
  logic wrEn1N = 1'b1;
  logic rdEn1N = 1'b1;
  logic rdEn2N = 1'b1;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] cfgRdData;
  logic [PTR_W-1:0] almostEmptyOff, almostFullOff;
  logic loadModeOn, fifoWrEn, fifoRdEn;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  fifo_thresh_loader #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_fifo_thresh_loader (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .ldN(ldN), .wrEn1N(wrEn1N),
    .rdEn1N(rdEn1N), .rdEn2N(rdEn2N), .dataIn(dataIn), .cfgRdData(cfgRdData),
    .almostEmptyOff(almostEmptyOff), .almostFullOff(almostFullOff),
    .loadModeOn(loadModeOn), .fifoWrEn(fifoWrEn), .fifoRdEn(fifoRdEn));

  // 125 MHz; read clock runs 2 ns behind the write clock
  initial forever #4 wrClk = ~wrClk;
  initial begin #2; forever #4 rdClk = ~rdClk; end

  // One write edge and one read edge pass, then sample 3 ns before next write edge
  task automatic tick();
    @(posedge wrClk);
    #5;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input bit loadSel);
    rstN = 1'b0; ldN = ~loadSel; wrEn1N = 1'b1; rdEn1N = 1'b1; rdEn2N = 1'b1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    ldN = 1'b1;
  endtask

  task automatic loadByte(input int val);
    ldN = 1'b0; wrEn1N = 1'b0; dataIn = DATA_W'(val);
    tick();
    wrEn1N = 1'b1;
  endtask

  task automatic readByte();
    ldN = 1'b0; rdEn1N = 1'b0; rdEn2N = 1'b0;
    tick();
    rdEn1N = 1'b1; rdEn2N = 1'b1;
  endtask

  task automatic t_reset();
    doReset(1'b1);
    check("R1 empty offset", int'(almostEmptyOff), 7);
    check("R1 full offset", int'(almostFullOff), 7);
    check("R1 readback", int'(cfgRdData), 0);
    check("R2 load mode on", int'(loadModeOn), 1);
  endtask

  task automatic t_load_seq();
    loadByte(9'h1A5);
    check("R3 emptyLo", int'(almostEmptyOff), 'h0A5);
    check("R7 no fifo write in load", int'(fifoWrEn), 0);
    loadByte(9'h0FF);
    check("R3 emptyHi", int'(almostEmptyOff), 'h3A5);
    check("R3 full untouched", int'(almostFullOff), 7);
    loadByte(9'h03C);
    check("R3 fullLo", int'(almostFullOff), 'h03C);
    loadByte(9'h0FE);
    check("R3 fullHi", int'(almostFullOff), 'h23C);
    check("R3 empty untouched", int'(almostEmptyOff), 'h3A5);
    loadByte(9'h011);
    check("R4 wrap to emptyLo", int'(almostEmptyOff), 'h311);
    check("R4 full after wrap", int'(almostFullOff), 'h23C);
  endtask

  task automatic t_readback();
    ldN = 1'b0; rdEn1N = 1'b0; rdEn2N = 1'b0; #1;
    check("R10 no fifo read during readback", int'(fifoRdEn), 0);
    readByte();
    check("R8 read emptyLo", int'(cfgRdData), 'h011);
    readByte();
    check("R11 read emptyHi zero-filled", int'(cfgRdData), 'h003);
    ldN = 1'b0; rdEn1N = 1'b1; rdEn2N = 1'b0;
    tick();
    check("R9 held with enable high", int'(cfgRdData), 'h003);
    ldN = 1'b1; rdEn1N = 1'b0; rdEn2N = 1'b0; #1;
    check("R10 fifo read with ldN high", int'(fifoRdEn), 1);
    tick();
    check("R9 held with ldN high", int'(cfgRdData), 'h003);
    readByte();
    check("R9 selector resumes at fullLo", int'(cfgRdData), 'h03C);
    readByte();
    check("R11 read fullHi zero-filled", int'(cfgRdData), 'h002);
    readByte();
    check("R8 read wrap to emptyLo", int'(cfgRdData), 'h011);
    ldN = 1'b1;
  endtask

  task automatic t_partial();
    doReset(1'b1);
    loadByte(9'h022);
    check("R5 first burst", int'(almostEmptyOff), 'h022);
    ldN = 1'b1; wrEn1N = 1'b0; dataIn = 9'h0FF; #1;
    check("R7 fifo write strobe", int'(fifoWrEn), 1);
    tick();
    check("R7 fifo write keeps empty", int'(almostEmptyOff), 'h022);
    check("R7 fifo write keeps full", int'(almostFullOff), 7);
    ldN = 1'b0; wrEn1N = 1'b1; #1;
    check("R7 no fifo write when ldN low", int'(fifoWrEn), 0);
    tick();
    check("R6 no-op keeps empty", int'(almostEmptyOff), 'h022);
    check("R6 no-op keeps full", int'(almostFullOff), 7);
    loadByte(9'h001);
    check("R5 resume at emptyHi", int'(almostEmptyOff), 'h122);
    ldN = 1'b1; tick();
    loadByte(9'h055);
    check("R5 resume at fullLo", int'(almostFullOff), 'h055);
    ldN = 1'b1;
  endtask

  task automatic t_two_enable();
    doReset(1'b0);
    check("R2 load mode off", int'(loadModeOn), 0);
    loadByte(9'h0AB);
    loadByte(9'h0CD);
    check("R2 empty kept", int'(almostEmptyOff), 7);
    check("R2 full kept", int'(almostFullOff), 7);
    ldN = 1'b1; wrEn1N = 1'b0; #1;
    check("R7 second enable writes", int'(fifoWrEn), 1);
    wrEn1N = 1'b1;
    ldN = 1'b0; rdEn1N = 1'b0; rdEn2N = 1'b0; #1;
    check("R10 fifo read in two-enable mode", int'(fifoRdEn), 1);
    tick();
    check("R2 no readback", int'(cfgRdData), 0);
    rdEn1N = 1'b1; rdEn2N = 1'b1; ldN = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_load_seq();
    t_readback();
    t_partial();
    t_two_enable();
    finish_run();
  end

endmodule